// File: doc/BRIEF.md
# Halt-Triggered Code Memory CRC Scanner

This block computes a 16-bit CRC over a region of code memory that begins at address zero. Software sets the size of the region with a 6-bit range value, arms the scanner with an enable bit and then puts the processor into its halt state. Entering halt while the scanner is armed starts the scan. The processor stays halted while the block reads code memory one byte per cycle through a synchronous read port and folds each byte into the CRC. When the last byte has been folded in, the block sends a one-cycle release pulse that wakes the processor.

The CRC accumulates into a result register that software can read and write. Software normally writes zero to it before a scan and compares the value afterwards against a reference it keeps itself. The result stays in the register after the enable bit is cleared.

Register map on the access port. Offsets are on `reg_addr`.
- Offset 0 is control: bit 0 is enable (read/write) and bit 1 is busy (read only).
- Offset 1 is range, in bits 5:0.
- Offset 2 is the 16-bit result.

Top module: `halt_crc_scanner`

## Requirements
- R1: After reset, control, range and result all read as zero, `halt_release` is low, and `mem_rd_en` is low.
- R2: A `halt_enter` pulse while idle with enable set starts a scan. In the next cycle `mem_rd_en` is high, `mem_addr` is 0, and control bit 1 (busy) reads as 1.
- R3: A `halt_enter` pulse with enable clear starts no scan. No memory read is issued, busy stays 0 and no release pulse follows.
- R4: Read addresses rise by one per cycle from 0 to a last address of (N+1)*1024-1, where N is the range value. Each address is issued exactly once, and then reads stop.
- R5: Each byte read is folded into the result, most significant bit first, with polynomial 0x1021. Bytes are folded in address order, starting from the value the result held when the scan started. Read data arrives one cycle after its address.
- R6: While idle, a write to offset 2 loads the result register with the written value.
- R7: `halt_release` is high for exactly one cycle per scan. The result already holds the final CRC in that cycle.
- R8: Busy is high from the cycle after the start until the cycle in which `halt_release` rises. In that cycle busy is low.
- R9: Writes to range and result while busy have no effect.
- R10: Clearing enable after a scan leaves the result unchanged and readable.
- R11: After a scan the block returns to idle, and a later armed halt starts a new scan.
- R12: Register read data appears on `reg_rdata` one cycle after `reg_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_enter | input | 1 | One-cycle pulse when the processor enters halt |
| halt_release | output | 1 | One-cycle pulse that ends the halt |
| mem_rd_en | output | 1 | Code memory read strobe |
| mem_addr | output | 16 | Code memory byte address |
| mem_rdata | input | 8 | Code memory data, valid one cycle after the strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data |

## Verification
Assertions check the following on every clock:
- the release pulse lasts one cycle;
- memory reads occur only while busy;
- consecutive read addresses step by one and never pass the last address;
- range and result do not move during a scan except when a byte is folded in;
- an unarmed halt never raises busy.

The CRC value itself, the exact last address for a given range, the start-from-held-value behaviour, the persistence after disabling, and the back-to-back scans can only be shown by the bench's scenarios. The bench compares against a reference model that it computes independently.

// File: rtl/crc_scan_pkg.sv
package crc_scan_pkg;
  localparam int CRC_W = 16;
  localparam logic [1:0] OFS_CTRL   = 2'd0;
  localparam logic [1:0] OFS_RANGE  = 2'd1;
  localparam logic [1:0] OFS_RESULT = 2'd2;

  typedef enum logic [1:0] {SC_IDLE, SC_SCAN, SC_DRAIN} scan_state_t;

  // Folds one byte into the CRC, most significant bit first.
  function automatic logic [CRC_W-1:0] crc_fold_byte(
    input logic [CRC_W-1:0] cur,
    input logic [7:0]       dat,
    input logic [CRC_W-1:0] poly
  );
    logic [CRC_W-1:0] c;
    logic fb;
    c = cur;
    for (int i = 7; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ dat[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ poly;
    end
    return c;
  endfunction
endpackage

// File: rtl/crc_scan_seq.sv
module crc_scan_seq
  import crc_scan_pkg::*;
#(
  parameter int RANGE_W    = 6,
  parameter int BLOCK_LOG2 = 10,
  localparam int ADDR_W    = RANGE_W + BLOCK_LOG2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               halt_enter,
  input  logic               enable,
  input  logic [RANGE_W-1:0] range_val,
  output logic               busy,
  output logic               mem_rd_en,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic               byte_valid,
  output logic               halt_release
);
  scan_state_t state;
  logic [ADDR_W-1:0] last_q;
  logic              last_inflight;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= SC_IDLE;
      busy          <= 1'b0;
      mem_rd_en     <= 1'b0;
      mem_addr      <= '0;
      last_q        <= '0;
      byte_valid    <= 1'b0;
      last_inflight <= 1'b0;
      halt_release  <= 1'b0;
    end else begin
      halt_release  <= 1'b0;
      byte_valid    <= mem_rd_en;
      last_inflight <= mem_rd_en && (mem_addr == last_q);
      case (state)
        SC_IDLE: begin
          if (halt_enter && enable) begin
            state     <= SC_SCAN;
            busy      <= 1'b1;
            mem_addr  <= '0;
            mem_rd_en <= 1'b1;
            last_q    <= {range_val, {BLOCK_LOG2{1'b1}}};
          end
        end
        SC_SCAN: begin
          if (mem_addr == last_q) begin
            mem_rd_en <= 1'b0;
            state     <= SC_DRAIN;
          end else begin
            mem_addr <= mem_addr + ADDR_W'(1);
          end
        end
        SC_DRAIN: begin
          if (last_inflight) begin
            halt_release <= 1'b1;
            busy         <= 1'b0;
            state        <= SC_IDLE;
          end
        end
        default: state <= SC_IDLE;
      endcase
    end
  end

  assert_release_single_R7: assert property (@(posedge clk) disable iff (rst)
    halt_release |=> !halt_release);
  assert_read_only_busy_R8: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> busy);
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));
  assert_addr_bound_R4: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (mem_addr <= last_q));
  assert_unarmed_halt_R3: assert property (@(posedge clk) disable iff (rst)
    (state == SC_IDLE && halt_enter && !enable) |=> !busy);
endmodule

// File: rtl/crc_scan_accum.sv
module crc_scan_accum
  import crc_scan_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic             sw_we,
  input  logic [CRC_W-1:0] sw_data,
  output logic [CRC_W-1:0] result
);
  always_ff @(posedge clk) begin
    if (rst)                 result <= '0;
    else if (byte_valid)     result <= crc_fold_byte(result, byte_data, POLY);
    else if (sw_we && !busy) result <= sw_data;
  end

  assert_result_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !byte_valid) |=> $stable(result));
endmodule

// File: rtl/crc_scan_regs.sv
module crc_scan_regs
  import crc_scan_pkg::*;
#(
  parameter int RANGE_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic               ctrl_wbit,
  input  logic [RANGE_W-1:0] range_wdata,
  input  logic               busy,
  input  logic [CRC_W-1:0]   result,
  output logic               enable,
  output logic [RANGE_W-1:0] range_val,
  output logic [CRC_W-1:0]   reg_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      enable    <= 1'b0;
      range_val <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_addr == OFS_CTRL)           enable    <= ctrl_wbit;
      if (reg_wr && reg_addr == OFS_RANGE && !busy) range_val <= range_wdata;
      case (reg_addr)
        OFS_CTRL:   reg_rdata <= {{(CRC_W-2){1'b0}}, busy, enable};
        OFS_RANGE:  reg_rdata <= CRC_W'(range_val);
        OFS_RESULT: reg_rdata <= result;
        default:    reg_rdata <= '0;
      endcase
    end
  end

  assert_range_locked_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(range_val));
endmodule

// File: rtl/halt_crc_scanner.sv
module halt_crc_scanner
  import crc_scan_pkg::*;
#(
  parameter int RANGE_W    = 6,
  parameter int BLOCK_LOG2 = 10,
  parameter logic [15:0] POLY = 16'h1021,
  localparam int ADDR_W    = RANGE_W + BLOCK_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_enter,
  output logic              halt_release,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata
);
  logic               enable, busy, byte_valid;
  logic [RANGE_W-1:0] range_val;
  logic [CRC_W-1:0]   result;

  crc_scan_regs #(.RANGE_W(RANGE_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .ctrl_wbit(reg_wdata[0]), .range_wdata(reg_wdata[RANGE_W-1:0]),
    .busy(busy), .result(result), .enable(enable),
    .range_val(range_val), .reg_rdata(reg_rdata)
  );

  crc_scan_seq #(.RANGE_W(RANGE_W), .BLOCK_LOG2(BLOCK_LOG2)) u_seq (
    .clk(clk), .rst(rst), .halt_enter(halt_enter), .enable(enable),
    .range_val(range_val), .busy(busy), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .byte_valid(byte_valid), .halt_release(halt_release)
  );

  crc_scan_accum #(.POLY(POLY)) u_accum (
    .clk(clk), .rst(rst), .busy(busy), .byte_valid(byte_valid),
    .byte_data(mem_rdata), .sw_we(reg_wr && reg_addr == OFS_RESULT),
    .sw_data(reg_wdata), .result(result)
  );
endmodule

// File: tb/sim_halt_crc_scanner.sv
module sim_halt_crc_scanner;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 0, rst = 1;
  logic halt_enter = 0, halt_release, mem_rd_en;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_rdata = 0;
  logic reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [15:0] reg_wdata = 0, reg_rdata;

  int tests = 0, fails = 0;
  int rd_count = 0, rel_count = 0;
  logic [AW-1:0] next_addr = 0;
  logic [AW-1:0] max_addr = 0;
  logic mon_done = 0;
  logic [15:0] exp_q[$];
  logic [15:0] last_result = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  halt_crc_scanner u0 (
    .clk(clk), .rst(rst), .halt_enter(halt_enter), .halt_release(halt_release),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
    return a[7:0] ^ {a[10:8], a[15:11]} ^ 8'h5A;
  endfunction

  function automatic logic [15:0] ref_crc(input logic [15:0] init, input int last);
    logic [15:0] c = init;
    for (int a = 0; a <= last; a++) begin
      logic [7:0] d = mem_byte(AW'(a));
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[15] ^ d[b];
        c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
    end
    return c;
  endfunction

  // memory model, one cycle read latency
  always @(posedge clk) if (mem_rd_en) mem_rdata <= mem_byte(mem_addr);

  // address monitor
  always @(posedge clk) begin
    if (!rst && mem_rd_en) begin
      if (mem_addr != next_addr) begin
        fails++;
        $display("FAIL R4 addr order: got %0d exp %0d", mem_addr, next_addr);
      end
      next_addr <= mem_addr + 1'b1;
      max_addr  <= mem_addr;
      rd_count  <= rd_count + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  // monitor: release pulses and result pop/compare
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && halt_release) begin
        logic [15:0] e, got;
        rel_count++;
        e = exp_q.pop_front();
        reg_addr = 2'd2;
        @(negedge clk);
        got = reg_rdata;
        check("R5 crc result", got, e);
        check("R7 release single cycle", halt_release, 0);
        last_result = got;
        mon_done = 1;
      end
    end
  end

  task automatic run_scan(input logic [5:0] n, input logic [15:0] init, input bit poke);
    logic [15:0] d;
    int last = (n + 1) * 1024 - 1;
    int rel0;
    reg_write(2'd1, {10'b0, n});
    reg_write(2'd2, init);
    reg_read(2'd2, d);
    check("R6 result write while idle", d, init);
    reg_write(2'd0, 16'h0001);
    exp_q.push_back(ref_crc(init, last));
    next_addr = 0; rd_count = 0; mon_done = 0; rel0 = rel_count;
    @(negedge clk); halt_enter = 1;
    @(negedge clk); halt_enter = 0;
    check("R2 read strobe after start", mem_rd_en, 1);
    check("R2 first address zero", mem_addr, 0);
    reg_read(2'd0, d);
    check("R8 busy during scan", d[1], 1);
    if (poke) begin
      reg_write(2'd2, 16'h1234);
      reg_write(2'd1, 16'h0005);
    end
    while (!mon_done) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R4 read count", rd_count, last + 1);
    check("R4 last address", max_addr, last);
    check("R7 one release per scan", rel_count - rel0, 1);
    reg_read(2'd0, d);
    check("R8 busy low after release", d[1], 0);
    if (poke) begin
      reg_read(2'd1, d);
      check("R9 range write ignored while busy", d, {10'b0, n});
    end
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 release low", halt_release, 0);
    check("R1 no read", mem_rd_en, 0);
    reg_read(2'd0, d); check("R1 ctrl zero", d, 0);
    check("R12 read data one cycle after address", d, 0);
    reg_read(2'd1, d); check("R1 range zero", d, 0);
    reg_read(2'd2, d); check("R1 result zero", d, 0);

    // R3: halt without enable
    @(negedge clk); halt_enter = 1;
    @(negedge clk); halt_enter = 0;
    repeat (20) @(negedge clk);
    check("R3 no reads when disabled", rd_count, 0);
    check("R3 no release when disabled", rel_count, 0);
    reg_read(2'd0, d); check("R3 busy stays low", d[1], 0);

    run_scan(6'd0, 16'h0000, 0);
    run_scan(6'd1, 16'hFFFF, 1);  // R9 result write during scan ignored -> R5 check

    // R10: disable and result persists
    reg_write(2'd0, 16'h0000);
    repeat (10) @(negedge clk);
    reg_read(2'd2, d); check("R10 result kept after disable", d, last_result);
    reg_read(2'd2, d); check("R10 result stable", d, last_result);

    run_scan(6'd0, 16'hBEEF, 0);  // R11 new scan after idle
    check("R11 second scan completed", exp_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule